// File: doc/BRIEF.md
# Three-Level Clamped-Leg Gate Pattern Generator

This block produces the twelve switch gate signals for a three-phase inverter whose legs each hold four series switches and can tie their output to the positive rail, to the DC midpoint, or to the negative rail. A phase accumulator sweeps one electrical period, advancing by a programmable step each clock. A delay angle, measured in accumulator units from the start of each half cycle, sets how long each leg stays at its outer levels. Inside each half period the leg sits at the outer level only between the delay angle and the half period minus the delay angle. Outside that window it rests at the midpoint.

The second and third legs follow the same staircase, lagging the first by one third and two thirds of the period. Each leg's level is translated into a four-switch combination. Within a leg the outer and inner switches form two complementary pairs, and a fixed dead gap separates one switch of a pair turning off from its partner turning on. A two-bit level code per leg is registered alongside the gates. New step and angle values are taken only when the accumulator wraps, so a period is never cut short. An angle of a quarter period or more is refused.

Top module: `npc3_gate_gen`

## Requirements
- R1: Per leg k, gate bits [4k+3:4k] are {S4,S3,S2,S1}. In steady state a positive level drives S1 and S2 on, the midpoint drives S2 and S3 on, and a negative level drives S3 and S4 on. The level code at lvl_o[2k+1:2k] is 01 for positive, 00 for midpoint and 11 for negative, and never 10.
- R2: With accumulator phase p (W bits) and active angle a, let q = p[W-2:0]. The leg is active when a <= q < 2^(W-1) - a. It is positive when active with p[W-1]=0, negative when active with p[W-1]=1, and at the midpoint otherwise.
- R3: While enabled, the accumulator advances by the active step every clock, giving a period of 2^W/step cycles.
- R4: Leg b uses phase p - floor(2^W/3) and leg c uses p - 2*floor(2^W/3), both taken modulo 2^W.
- R5: While enabled, step_i and alpha_i are adopted only on the clock where the accumulator carries out. While disabled, they are adopted every clock.
- R6: An alpha_i of 2^(W-2) or more is never adopted, and the previously active angle stays in force.
- R7: S1 and S3 are never on together, and neither are S2 and S4. After one switch of a pair turns off, its partner stays off for max(DEAD_CYC,1) clocks before turning on.
- R8: The level code is updated on the same clock edge on which the off-going gate of a transition falls.
- R9: Reset puts every leg at the midpoint state (S2 and S3 on), gives level code 00, and clears the accumulator, step and angle.
- R10: While en_i is low, the accumulator is held at zero and every leg is steered to the midpoint state through the dead-gap sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds the accumulator and parks the legs at the midpoint |
| step_i | input | W | Phase increment per clock |
| alpha_i | input | W-1 | Delay angle in phase units, valid below 2^(W-2) |
| gate_o | output | 12 | Gate drives, leg k at bits [4k+3:4k] as {S4,S3,S2,S1} |
| lvl_o | output | 6 | Level code per leg, leg k at bits [2k+1:2k] |

## Verification
The hardest case to reach from the ports is a parameter update that must wait for the accumulator to wrap. The new step or angle is presented mid-period, and nothing may change until the carry. An out-of-range angle must also leave the running angle untouched. The stimulus presents such values at arbitrary points in a period and lets a cycle-level predictor follow the wrap instants. Pulse widths are then counted over whole periods, which shows when the new angle took effect and that a rejected angle changed nothing.

// File: rtl/npc3_pkg.sv
package npc3_pkg;
  typedef enum logic [1:0] {
    LVL_MID = 2'b00,
    LVL_POS = 2'b01,
    LVL_NEG = 2'b11
  } lvl_e;

  localparam int unsigned LEGS = 3;
  localparam int unsigned SW_PER_LEG = 4;
endpackage

// File: rtl/npc3_phase_acc.sv
module npc3_phase_acc #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] step_i,
  input  logic [W-2:0] alpha_i,
  output logic [W-1:0] ph_o,
  output logic [W-2:0] alpha_o,
  output logic         wrap_o
);
  localparam logic [W-2:0] QUARTER = (W-1)'(2**(W-2));

  logic [W-1:0] step_q;
  logic [W:0]   sum;
  logic         alpha_ok;

  assign sum      = {1'b0, ph_o} + {1'b0, step_q};
  assign alpha_ok = alpha_i < QUARTER;
  assign wrap_o   = en & sum[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_o    <= '0;
      step_q  <= '0;
      alpha_o <= '0;
    end else if (!en) begin
      ph_o   <= '0;
      step_q <= step_i;
      if (alpha_ok) alpha_o <= alpha_i;
    end else begin
      ph_o <= sum[W-1:0];
      if (sum[W]) begin
        step_q <= step_i;
        if (alpha_ok) alpha_o <= alpha_i;
      end
    end
  end
endmodule

// File: rtl/npc3_level_sel.sv
module npc3_level_sel
  import npc3_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         en,
  input  logic [W-1:0] ph,
  input  logic [W-2:0] alpha,
  output lvl_e         lvl [LEGS]
);
  localparam int unsigned THIRD = (2**W) / 3;
  localparam logic [W-1:0] HALF = W'(2**(W-1));

  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    localparam logic [W-1:0] OFFK = W'((k * THIRD) % (2**W));
    logic [W-1:0] p;
    logic         act;

    assign p   = ph - OFFK;
    assign act = ({1'b0, p[W-2:0]} >= {1'b0, alpha}) &&
                 ({1'b0, p[W-2:0]} < (HALF - {1'b0, alpha}));

    always_comb begin
      if (!en || !act) lvl[k] = LVL_MID;
      else if (p[W-1]) lvl[k] = LVL_NEG;
      else             lvl[k] = LVL_POS;
    end
  end
endmodule

// File: rtl/npc3_pair_dt.sv
module npc3_pair_dt #(
  parameter int unsigned DEAD   = 3,
  parameter bit          RST_HI = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic want_hi,
  output logic hi,
  output logic lo
);
  localparam int unsigned CW = $clog2(DEAD + 2);

  logic [CW-1:0] cnt;
  logic          want_lo;

  assign want_lo = ~want_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi  <= RST_HI;
      lo  <= ~RST_HI;
      cnt <= '0;
    end else if (hi == want_hi && lo == want_lo) begin
      cnt <= '0;
    end else if (hi | lo) begin
      hi  <= 1'b0;
      lo  <= 1'b0;
      cnt <= CW'(1);
    end else if (cnt >= CW'(DEAD)) begin
      hi  <= want_hi;
      lo  <= want_lo;
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/npc3_gate_map.sv
module npc3_gate_map
  import npc3_pkg::*;
#(
  parameter int unsigned DEAD = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  lvl_e                         lvl [LEGS],
  output logic [LEGS*SW_PER_LEG-1:0]   gate_o,
  output logic [LEGS*2-1:0]            lvl_o
);
  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    logic s1, s2, s3, s4;

    // outer pair: S1 on only at the positive level
    npc3_pair_dt #(.DEAD(DEAD), .RST_HI(1'b0)) u_outer (
      .clk(clk), .rst(rst), .want_hi(lvl[k] == LVL_POS), .hi(s1), .lo(s3)
    );
    // inner pair: S2 on unless at the negative level
    npc3_pair_dt #(.DEAD(DEAD), .RST_HI(1'b1)) u_inner (
      .clk(clk), .rst(rst), .want_hi(lvl[k] != LVL_NEG), .hi(s2), .lo(s4)
    );

    assign gate_o[SW_PER_LEG*k +: SW_PER_LEG] = {s4, s3, s2, s1};

    always_ff @(posedge clk) begin
      if (rst) lvl_o[2*k +: 2] <= LVL_MID;
      else     lvl_o[2*k +: 2] <= lvl[k];
    end
  end
endmodule

// File: rtl/npc3_gate_gen.sv
module npc3_gate_gen
  import npc3_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  input  logic [W-2:0] alpha_i,
  output logic [11:0]  gate_o,
  output logic [5:0]   lvl_o
);
  logic [W-1:0] ph;
  logic [W-2:0] alpha_act;
  logic         wrap;
  lvl_e         lvl [LEGS];

  npc3_phase_acc #(.W(W)) u_acc (
    .clk(clk_i), .rst(rst_i), .en(en_i), .step_i(step_i), .alpha_i(alpha_i),
    .ph_o(ph), .alpha_o(alpha_act), .wrap_o(wrap)
  );

  npc3_level_sel #(.W(W)) u_sel (
    .en(en_i), .ph(ph), .alpha(alpha_act), .lvl(lvl)
  );

  npc3_gate_map #(.DEAD(DEAD_CYC)) u_map (
    .clk(clk_i), .rst(rst_i), .lvl(lvl), .gate_o(gate_o), .lvl_o(lvl_o)
  );
endmodule

// File: rtl/npc3_gate_chk.sv
module npc3_gate_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         wrap,
  input logic [W-1:0] ph,
  input logic [W-2:0] alpha_act,
  input logic [11:0]  gate,
  input logic [5:0]   lvl
);
  localparam logic [W-2:0] QUARTER = (W-1)'(2**(W-2));

  for (genvar k = 0; k < 3; k++) begin : g_leg
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
      !(gate[4*k] && gate[4*k+2]) && !(gate[4*k+1] && gate[4*k+3]));
    assert_outer_gap_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(gate[4*k]) |-> !gate[4*k+2]);
    assert_inner_gap_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(gate[4*k+3]) |-> !gate[4*k+1]);
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
      lvl[2*k +: 2] != 2'b10);
  end

  assert_alpha_range_R6: assert property (@(posedge clk) disable iff (rst)
    alpha_act < QUARTER);
  assert_hold_params_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> $stable(alpha_act));
  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> ph == '0);
  assert_reset_mid_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate == 12'b0110_0110_0110 && lvl == 6'b0));
endmodule

bind npc3_gate_gen npc3_gate_chk #(.W(W)) u_chk (
  .clk(clk_i), .rst(rst_i), .en(en_i), .wrap(wrap), .ph(ph),
  .alpha_act(alpha_act), .gate(gate_o), .lvl(lvl_o)
);

// File: tb/test_npc3_gate_gen.sv
module test_npc3_gate_gen;
  localparam int W = 12;
  localparam int DEAD = 3;
  localparam int THIRD = 4096 / 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [W-1:0] step = '0;
  logic [W-2:0] alpha = '0;
  logic [11:0] gate;
  logic [5:0] lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  npc3_gate_gen #(.W(W), .DEAD_CYC(DEAD)) i_npc3_gate_gen (
    .clk_i(clk), .rst_i(rst), .en_i(en), .step_i(step), .alpha_i(alpha),
    .gate_o(gate), .lvl_o(lvl)
  );

  typedef struct packed { logic [5:0] l; logic [11:0] g; } exp_t;
  exp_t sb [$];

  // predictor state
  logic [W-1:0] m_ph = '0, m_step = '0;
  logic [W-2:0] m_alpha = '0;
  logic [11:0] m_g = 12'b0110_0110_0110;
  logic [5:0] m_l = '0;
  int m_cnt [6];

  task automatic pair_step(int idx, int hb, int lb, bit want_hi);
    bit h, l;
    h = m_g[hb]; l = m_g[lb];
    if (h == want_hi && l == !want_hi) m_cnt[idx] = 0;
    else if (h || l) begin m_g[hb] = 0; m_g[lb] = 0; m_cnt[idx] = 1; end
    else if (m_cnt[idx] >= DEAD) begin
      m_g[hb] = want_hi; m_g[lb] = !want_hi; m_cnt[idx] = 0;
    end else m_cnt[idx] = m_cnt[idx] + 1;
  endtask

  always @(posedge clk) begin
    logic [W:0] s;
    if (rst) begin
      m_ph = '0; m_step = '0; m_alpha = '0;
      m_g = 12'b0110_0110_0110; m_l = '0;
      for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        logic [W-1:0] p;
        logic [1:0] d;
        p = m_ph - W'(k * THIRD);
        d = 2'b00;
        if (en && {1'b0, p[W-2:0]} >= {1'b0, m_alpha} &&
            int'(p[W-2:0]) < 2048 - int'(m_alpha))
          d = p[W-1] ? 2'b11 : 2'b01;
        m_l[2*k +: 2] = d;
        pair_step(2*k, 4*k, 4*k+2, d == 2'b01);
        pair_step(2*k+1, 4*k+1, 4*k+3, d != 2'b11);
      end
      if (!en) begin
        m_ph = '0; m_step = step;
        if (alpha < 1024) m_alpha = alpha;
      end else begin
        s = {1'b0, m_ph} + {1'b0, m_step};
        m_ph = s[W-1:0];
        if (s[W]) begin
          m_step = step;
          if (alpha < 1024) m_alpha = alpha;
        end
      end
    end
    sb.push_back('{l: m_l, g: m_g});
  end

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0 && !done) begin
      e = sb.pop_front();
      n_chk++;
      if (lvl !== e.l) begin
        n_bad++;
        $display("FAIL R2 R4 R8 level code: actual %b expected %b at %0t", lvl, e.l, $time);
      end
      n_chk++;
      if (gate !== e.g) begin
        n_bad++;
        $display("FAIL R1 R7 gates: actual %b expected %b at %0t", gate, e.g, $time);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_code(int leg, logic [1:0] code, int ncyc, output int c);
    c = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (lvl[2*leg +: 2] == code) c++;
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    int c;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset gates", gate, 12'b0110_0110_0110);
    check("R9 reset level", lvl, 0);

    // start: step 64 -> 64-cycle period, alpha 256
    step = 64; alpha = 256;
    wait_cyc(2);
    en = 1'b1;
    wait_cyc(130);
    count_code(0, 2'b01, 64, c); check("R2 leg a positive span", c, 24);
    count_code(0, 2'b11, 64, c); check("R2 leg a negative span", c, 24);
    count_code(0, 2'b00, 64, c); check("R2 leg a midpoint span", c, 16);
    count_code(1, 2'b01, 64, c); check("R4 leg b positive span", c, 24);
    count_code(2, 2'b11, 64, c); check("R4 leg c negative span", c, 24);

    // dead gap on leg a outer pair
    begin
      int gap = 0;
      bit seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
        logic p1;
        p1 = gate[0];
        @(negedge clk);
        if (p1 && !gate[0]) seen = 1;
      end
      while (seen && gate[0] == 0 && gate[2] == 0 && gap < 20) begin
        gap++;
        @(negedge clk);
      end
      check("R7 outer dead gap", gap, DEAD);
    end

    // R6: out-of-range angle is refused
    alpha = 1024;
    wait_cyc(140);
    count_code(0, 2'b01, 64, c); check("R6 span kept after refused angle", c, 24);

    // R5/R3: new step and angle mid-period
    alpha = 512; step = 128;
    wait_cyc(5);
    count_code(0, 2'b01, 20, c);
    wait_cyc(140);
    count_code(0, 2'b01, 32, c); check("R5 new angle span", c, 8);
    count_code(0, 2'b11, 32, c); check("R3 halved period negative span", c, 8);
    count_code(0, 2'b00, 32, c); check("R3 halved period midpoint span", c, 16);

    // R10: disable parks the legs at midpoint
    en = 1'b0;
    wait_cyc(2 * DEAD + 4);
    @(negedge clk);
    check("R10 disabled gates", gate, 12'b0110_0110_0110);
    check("R10 disabled level", lvl, 0);
    en = 1'b1;
    wait_cyc(80);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule